// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a byte-wide parallel host bus and the back end of a flash array. Host writes never reach the array directly. Each write that carries an active sector select goes to a sequence decoder. That decoder recognises a two-write unlock prefix, a command byte and any trailing address/data writes. When a sequence is complete and legal, the block raises a one-cycle strobe with an operation code, address and data. The back end performs the program or erase and reports completion with a done pulse.

Reads are served combinationally from one of three sources:
- the array, in the normal state;
- a fixed identifier byte or a per-sector protection flag, after an identify command;
- a status byte, while an operation is running.

A partial sequence returns to the normal state in three cases: a wrong byte, a wrong address, or a gap longer than a parameterised number of clock cycles between two accepted writes. An 8-bit protection register, loaded through a side port, blocks program and erase commands aimed at protected sectors.

States:
- `ST_ARRAY`: normal read.
- `ST_UNLK1`: first unlock write seen.
- `ST_UNLK2`: second unlock write seen.
- `ST_IDENT`: identifier and protection reads.
- `ST_PROG`: waiting for the program address/data write.
- `ST_ERSETUP`: erase setup seen.
- `ST_EUNLK1` and `ST_EUNLK2`: the second unlock pair.
- `ST_BUSY`: operation running.

Transitions:
- ARRAY→UNLK1 on AAh@555h.
- UNLK1→UNLK2 on 55h@AAAh.
- From UNLK2, a write at 555h selects the next state: 90h→IDENT, A0h→PROG, 80h→ERSETUP, F0h→ARRAY.
- ERSETUP→EUNLK1 on AAh@555h.
- EUNLK1→EUNLK2 on 55h@AAAh.
- EUNLK2→BUSY on 10h@555h (whole chip) or 30h (sector).
- PROG→BUSY on any unprotected write.
- IDENT→ARRAY on any write.
- BUSY→ARRAY on the done pulse.
- Any mismatch, protected target or timeout in a partial state leads to ARRAY.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the block is in the normal state with no strobe. A read in the normal state returns `arr_rdata` unchanged.
- R2: The unlock prefix is AAh written where address bits [11:0] equal 555h, then 55h written where bits [11:0] equal AAAh. Address bits [18:12] take no part in the match.
- R3: In a partial sequence, a write with an unexpected data byte or address returns the block to the normal state. A command byte that follows such a write then has no effect.
- R4: A partial sequence is abandoned when the next accepted write arrives more than TMO_CYC cycles after the previous one. A write exactly TMO_CYC cycles later is still accepted.
- R5: A write with `sect_sel` all zero is ignored and leaves the sequence state unchanged. `sect_sel` is at most one-hot.
- R6: After the unlock prefix and 90h@555h, a read with addr[6]=0, addr[1]=0, addr[0]=1 and a sector selected returns E7h.
- R7: In the same identify state, a read with addr[6]=0, addr[1]=1, addr[0]=0 returns 01h if the selected sector's protection bit is set and 00h otherwise. Other reads there return 00h.
- R8: Any write in the identify state returns the block to the normal state. Unlock prefix followed by F0h@555h also returns to the normal state.
- R9: Unlock prefix, A0h@555h, then one address/data write produces a `cmd_stb` pulse in the cycle after that write. The pulse carries `cmd_op`=0 (program) and that write's address and data.
- R10: Unlock prefix, 80h@555h and a second unlock prefix are followed by the final erase write. 10h@555h gives `cmd_op`=1 (whole chip). 30h at any address gives `cmd_op`=2 (sector) with that address.
- R11: No strobe is issued and the block returns to the normal state in three cases: a program or sector erase whose selected sector is protected, or a chip erase while any protection bit is set.
- R12: While busy, a read returns the status byte {4'b0, erase, 2'b0, suspended}. Other writes are ignored. During a sector erase only, B0h issues `cmd_op`=3 (suspend) and 30h while suspended issues `cmd_op`=4 (resume). `be_done` returns the block to the normal state.
- R13: `prot_ld` loads `prot_din` into the protection register, one bit per sector select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Host address |
| wdata | input | 8 | Host write data |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| rd_en | input | 1 | Host read strobe |
| sect_sel | input | SECT_N | One-hot sector select |
| arr_rdata | input | 8 | Array read data from the back end |
| prot_ld | input | 1 | Load strobe for the protection register |
| prot_din | input | SECT_N | New protection flags |
| be_done | input | 1 | Back end finished the current operation |
| rd_data | output | 8 | Read data, zero when rd_en is low |
| cmd_stb | output | 1 | One-cycle command issue strobe |
| cmd_op | output | 3 | 0 program, 1 chip erase, 2 sector erase, 3 suspend, 4 resume |
| cmd_addr | output | ADDR_W | Address of the write that issued the command |
| cmd_data | output | 8 | Data of the write that issued the command |

## Verification
The checks assume the following about the inputs:
- `sect_sel` never has more than one bit set.
- `wr_en` and `rd_en` are never both high.
- `be_done` pulses only after a command has been issued.

The stimulus drives every bus cycle through write, read and idle tasks, which keep these rules by construction. The tasks always use single-bit sector constants, and the back end's done pulse is raised only after a strobe has been expected. The timeout checks use an idle gap of exactly TMO_CYC-1 and TMO_CYC cycles, which places the next write on each side of the limit.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [3:0] {
        ST_ARRAY,
        ST_UNLK1,
        ST_UNLK2,
        ST_IDENT,
        ST_PROG,
        ST_ERSETUP,
        ST_EUNLK1,
        ST_EUNLK2,
        ST_BUSY
    } fcd_state_e;

    typedef enum logic [2:0] {
        OP_PROG   = 3'd0,
        OP_CHIP   = 3'd1,
        OP_SECT   = 3'd2,
        OP_SUSP   = 3'd3,
        OP_RESUME = 3'd4
    } fcd_op_e;

    localparam logic [7:0]  KEY_FIRST   = 8'hAA;
    localparam logic [7:0]  KEY_SECOND  = 8'h55;
    localparam logic [7:0]  CMD_IDENT   = 8'h90;
    localparam logic [7:0]  CMD_RESET   = 8'hF0;
    localparam logic [7:0]  CMD_PROG    = 8'hA0;
    localparam logic [7:0]  CMD_ERASE   = 8'h80;
    localparam logic [7:0]  CMD_CHIP    = 8'h10;
    localparam logic [7:0]  CMD_SECT    = 8'h30;
    localparam logic [7:0]  CMD_SUSP    = 8'hB0;
    localparam logic [7:0]  ID_VALUE    = 8'hE7;
    localparam logic [11:0] LOC_FIRST   = 12'h555;
    localparam logic [11:0] LOC_SECOND  = 12'hAAA;

endpackage

// File: rtl/fcd_addr_match.sv
module fcd_addr_match
    import fcd_pkg::*;
#(
    parameter int MATCH_W = 12
) (
    input  logic [MATCH_W-1:0] low_addr,
    output logic               hit_first,
    output logic               hit_second,
    output logic               id_sel,
    output logic               pr_sel
);
    always_comb begin
        hit_first  = (low_addr == MATCH_W'(LOC_FIRST));
        hit_second = (low_addr == MATCH_W'(LOC_SECOND));
        id_sel     = !low_addr[6] && !low_addr[1] &&  low_addr[0];
        pr_sel     = !low_addr[6] &&  low_addr[1] && !low_addr[0];
    end
endmodule

// File: rtl/fcd_timer.sv
module fcd_timer #(
    parameter int TMO_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expire
);
    localparam int CW = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = run && !restart && (cnt_q == LAST);
endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux #(
    parameter int DATA_W = 8
) (
    input  logic              rd_en,
    input  logic              in_ident,
    input  logic              in_busy,
    input  logic              id_sel,
    input  logic              pr_sel,
    input  logic              sel_any,
    input  logic              prot_hit,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] id_value,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (in_busy) begin
                rd_data = status;
            end else if (in_ident) begin
                if (id_sel && sel_any) begin
                    rd_data = id_value;
                end else if (pr_sel) begin
                    rd_data = DATA_W'(prot_hit);
                end
            end else begin
                rd_data = arr_rdata;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int SECT_N  = 8,
    parameter int TMO_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [SECT_N-1:0] sect_sel,
    input  logic [7:0]        arr_rdata,
    input  logic              prot_ld,
    input  logic [SECT_N-1:0] prot_din,
    input  logic              be_done,
    output logic [7:0]        rd_data,
    output logic              cmd_stb,
    output logic [2:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data
);
    localparam int MATCH_W = 12;

    fcd_state_e        st_q, st_d;
    fcd_op_e           op_d;
    logic [SECT_N-1:0] prot_q;
    logic              ers_q, ers_d, sect_q, sect_d, susp_q, susp_d;
    logic              stb_d;
    logic              sel_any, prot_hit, wr_go;
    logic              hit_a, hit_b, id_sel, pr_sel;
    logic              run_tmo, tmo_expire;
    logic [7:0]        status;

    assign sel_any  = |sect_sel;
    assign prot_hit = |(prot_q & sect_sel);
    assign wr_go    = wr_en && sel_any;
    assign status   = {4'b0000, ers_q, 2'b00, susp_q};
    assign run_tmo  = (st_q == ST_UNLK1)   || (st_q == ST_UNLK2) ||
                      (st_q == ST_PROG)    || (st_q == ST_ERSETUP) ||
                      (st_q == ST_EUNLK1)  || (st_q == ST_EUNLK2);

    fcd_addr_match #(.MATCH_W(MATCH_W)) u_match (
        .low_addr   (addr[MATCH_W-1:0]),
        .hit_first  (hit_a),
        .hit_second (hit_b),
        .id_sel     (id_sel),
        .pr_sel     (pr_sel)
    );

    fcd_timer #(.TMO_CYC(TMO_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_tmo),
        .restart (wr_go),
        .expire  (tmo_expire)
    );

    fcd_read_mux #(.DATA_W(8)) u_rmux (
        .rd_en     (rd_en),
        .in_ident  (st_q == ST_IDENT),
        .in_busy   (st_q == ST_BUSY),
        .id_sel    (id_sel),
        .pr_sel    (pr_sel),
        .sel_any   (sel_any),
        .prot_hit  (prot_hit),
        .status    (status),
        .id_value  (ID_VALUE),
        .arr_rdata (arr_rdata),
        .rd_data   (rd_data)
    );

    // next-state and command decision
    always_comb begin
        st_d   = st_q;
        op_d   = OP_PROG;
        stb_d  = 1'b0;
        ers_d  = ers_q;
        sect_d = sect_q;
        susp_d = susp_q;
        unique case (st_q)
            ST_ARRAY: begin
                if (wr_go && wdata == KEY_FIRST && hit_a) st_d = ST_UNLK1;
            end
            ST_UNLK1, ST_EUNLK1: begin
                if (wr_go) begin
                    if (wdata == KEY_SECOND && hit_b)
                        st_d = (st_q == ST_UNLK1) ? ST_UNLK2 : ST_EUNLK2;
                    else
                        st_d = ST_ARRAY;
                end else if (tmo_expire) begin
                    st_d = ST_ARRAY;
                end
            end
            ST_UNLK2: begin
                if (wr_go) begin
                    st_d = ST_ARRAY;
                    if (hit_a) begin
                        if (wdata == CMD_IDENT)      st_d = ST_IDENT;
                        else if (wdata == CMD_PROG)  st_d = ST_PROG;
                        else if (wdata == CMD_ERASE) st_d = ST_ERSETUP;
                    end
                end else if (tmo_expire) begin
                    st_d = ST_ARRAY;
                end
            end
            ST_IDENT: begin
                if (wr_go) st_d = ST_ARRAY;
            end
            ST_PROG: begin
                if (wr_go) begin
                    if (prot_hit) begin
                        st_d = ST_ARRAY;
                    end else begin
                        st_d   = ST_BUSY;
                        stb_d  = 1'b1;
                        op_d   = OP_PROG;
                        ers_d  = 1'b0;
                        sect_d = 1'b0;
                    end
                end else if (tmo_expire) begin
                    st_d = ST_ARRAY;
                end
            end
            ST_ERSETUP: begin
                if (wr_go)
                    st_d = (wdata == KEY_FIRST && hit_a) ? ST_EUNLK1 : ST_ARRAY;
                else if (tmo_expire)
                    st_d = ST_ARRAY;
            end
            ST_EUNLK2: begin
                if (wr_go) begin
                    st_d = ST_ARRAY;
                    if (wdata == CMD_CHIP && hit_a && prot_q == '0) begin
                        st_d   = ST_BUSY;
                        stb_d  = 1'b1;
                        op_d   = OP_CHIP;
                        ers_d  = 1'b1;
                        sect_d = 1'b0;
                    end else if (wdata == CMD_SECT && !prot_hit) begin
                        st_d   = ST_BUSY;
                        stb_d  = 1'b1;
                        op_d   = OP_SECT;
                        ers_d  = 1'b1;
                        sect_d = 1'b1;
                    end
                end else if (tmo_expire) begin
                    st_d = ST_ARRAY;
                end
            end
            ST_BUSY: begin
                if (be_done) begin
                    st_d   = ST_ARRAY;
                    ers_d  = 1'b0;
                    sect_d = 1'b0;
                    susp_d = 1'b0;
                end else if (wr_go && sect_q) begin
                    if (wdata == CMD_SUSP && !susp_q) begin
                        stb_d  = 1'b1;
                        op_d   = OP_SUSP;
                        susp_d = 1'b1;
                    end else if (wdata == CMD_SECT && susp_q) begin
                        stb_d  = 1'b1;
                        op_d   = OP_RESUME;
                        susp_d = 1'b0;
                    end
                end
            end
            default: st_d = ST_ARRAY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_ARRAY;
            ers_q  <= 1'b0;
            sect_q <= 1'b0;
            susp_q <= 1'b0;
            prot_q <= '0;
        end else begin
            st_q   <= st_d;
            ers_q  <= ers_d;
            sect_q <= sect_d;
            susp_q <= susp_d;
            if (prot_ld) prot_q <= prot_din;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_stb  <= 1'b0;
            cmd_op   <= 3'd0;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else begin
            cmd_stb <= stb_d;
            if (stb_d) begin
                cmd_op   <= op_d;
                cmd_addr <= addr;
                cmd_data <= wdata;
            end
        end
    end
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SECT_N = 8
) (
    input logic              clk,
    input logic              rst_n,
    input fcd_state_e        st,
    input logic              rd_en,
    input logic              wr_en,
    input logic [7:0]        rd_data,
    input logic [7:0]        arr_rdata,
    input logic [ADDR_W-1:0] addr,
    input logic [SECT_N-1:0] sect_sel,
    input logic [SECT_N-1:0] prot_q,
    input logic              tmo_expire,
    input logic              cmd_stb,
    input logic [2:0]        cmd_op
);
    AST_ARRAY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARRAY && rd_en) |-> rd_data == arr_rdata); // R1

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sect_sel)); // R5

    AST_TMO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_expire |=> st == ST_ARRAY); // R4

    AST_ID_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDENT && rd_en && sect_sel != '0 && !addr[6] && !addr[1] && addr[0])
        |-> rd_data == ID_VALUE); // R6

    AST_STB_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> $past(wr_en)); // R9

    AST_PROT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_op == 3'd0) |-> ($past(prot_q) & $past(sect_sel)) == '0); // R11
endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W), .SECT_N(SECT_N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st_q),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .rd_data    (rd_data),
    .arr_rdata  (arr_rdata),
    .addr       (addr),
    .sect_sel   (sect_sel),
    .prot_q     (prot_q),
    .tmo_expire (tmo_expire),
    .cmd_stb    (cmd_stb),
    .cmd_op     (cmd_op)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
    localparam int AW  = 19;
    localparam int SN  = 8;
    localparam int TMO = 16;
    localparam logic [SN-1:0] S0 = 8'h01, S1 = 8'h02, S2 = 8'h04;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [SN-1:0] sect_sel = '0;
    logic [7:0]    arr_rdata;
    logic          prot_ld = 1'b0;
    logic [SN-1:0] prot_din = '0;
    logic          be_done = 1'b0;
    logic [7:0]    rd_data;
    logic          cmd_stb;
    logic [2:0]    cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [7:0]    cmd_data;

    int checks = 0, failures = 0;
    bit finished = 0;

    logic [7:0]       rd_q[$];
    string            rd_tag[$];
    logic [AW+10:0]   stb_q[$];
    string            stb_tag[$];

    always #2.5 clk = ~clk;

    assign arr_rdata = addr[7:0] ^ 8'h5A;

    flash_cmd_decoder #(.ADDR_W(AW), .SECT_N(SN), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .sect_sel(sect_sel), .arr_rdata(arr_rdata),
        .prot_ld(prot_ld), .prot_din(prot_din), .be_done(be_done),
        .rd_data(rd_data), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    function automatic logic [7:0] arr(input logic [AW-1:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clr();
        wr_en = 0; rd_en = 0; be_done = 0; prot_ld = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; clr();
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic [SN-1:0] s);
        @(posedge clk); #1; clr();
        addr = a; wdata = d; sect_sel = s; wr_en = 1;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [SN-1:0] s,
                      input logic [7:0] exp, input string req);
        @(posedge clk); #1; clr();
        rd_q.push_back(exp); rd_tag.push_back(req);
        addr = a; sect_sel = s; rd_en = 1;
    endtask

    task automatic expect_stb(input logic [2:0] op, input logic [AW-1:0] a,
                              input logic [7:0] d, input string req);
        stb_q.push_back({op, a, d}); stb_tag.push_back(req);
    endtask

    task automatic unlock();
        wr(19'h00555, 8'hAA, S0);
        wr(19'h00AAA, 8'h55, S0);
    endtask

    task automatic done_pulse();
        @(posedge clk); #1; clr(); be_done = 1;
    endtask

    task automatic load_prot(input logic [SN-1:0] p);
        @(posedge clk); #1; clr(); prot_din = p; prot_ld = 1;
    endtask

    // monitor: compares outputs against the scoreboard queues
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rd_en) begin
                if (rd_q.size() == 0) begin
                    check(0, "R1", "read with empty queue", {24'd0, rd_data}, 0);
                end else begin
                    automatic logic [7:0] e = rd_q.pop_front();
                    automatic string t = rd_tag.pop_front();
                    check(rd_data == e, t, "rd_data", {24'd0, rd_data}, {24'd0, e});
                end
            end
            if (cmd_stb) begin
                if (stb_q.size() == 0) begin
                    check(0, "R11", "unexpected cmd_stb", {29'd0, cmd_op}, 0);
                end else begin
                    automatic logic [AW+10:0] e = stb_q.pop_front();
                    automatic string t = stb_tag.pop_front();
                    check({cmd_op, cmd_addr, cmd_data} == e, t, "strobe",
                          {2'b0, cmd_op, cmd_addr, cmd_data}, {2'b0, e});
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            check(rd_q.size() == 0 && stb_q.size() == 0, "R9", "queues drained",
                  rd_q.size() + stb_q.size(), 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        check(0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(cmd_stb == 0, "R1", "cmd_stb after reset", cmd_stb, 0);
        rd(19'h00123, S0, arr(19'h00123), "R1");

        // R13 / R7 / R6: protection load and identify reads
        load_prot(S2);
        unlock(); wr(19'h00555, 8'h90, S0);
        rd(19'h00002, S2, 8'h01, "R7");
        rd(19'h00002, S0, 8'h00, "R13");
        rd(19'h00001, S0, 8'hE7, "R6");
        rd(19'h00041, S0, 8'h00, "R7");
        wr(19'h00000, 8'h00, S0);                 // any write leaves identify
        rd(19'h00010, S0, arr(19'h00010), "R8");

        // R2: upper address bits ignored
        wr(19'h7F555, 8'hAA, S1);
        wr(19'h12AAA, 8'h55, S1);
        wr(19'h40555, 8'h90, S1);
        rd(19'h30001, S1, 8'hE7, "R2");
        unlock(); wr(19'h00555, 8'hF0, S0);       // R8 reset sequence
        rd(19'h00020, S0, arr(19'h00020), "R8");

        // R3: wrong data, then wrong address
        wr(19'h00555, 8'hAA, S0); wr(19'h00AAA, 8'h56, S0); wr(19'h00555, 8'h90, S0);
        rd(19'h00001, S0, arr(19'h00001), "R3");
        wr(19'h00555, 8'hAA, S0); wr(19'h00AAB, 8'h55, S0); wr(19'h00555, 8'h90, S0);
        rd(19'h00001, S0, arr(19'h00001), "R3");

        // R5: write with no sector select is ignored
        wr(19'h00555, 8'hAA, S0); wr(19'h00AAA, 8'h12, '0);
        wr(19'h00AAA, 8'h55, S0); wr(19'h00555, 8'h90, S0);
        rd(19'h00001, S0, 8'hE7, "R5");
        wr(19'h00555, 8'hF0, S0);

        // R4: gap of exactly TMO cycles accepted, TMO+1 aborts
        wr(19'h00555, 8'hAA, S0); idle(TMO - 1);
        wr(19'h00AAA, 8'h55, S0); wr(19'h00555, 8'h90, S0);
        rd(19'h00001, S0, 8'hE7, "R4");
        wr(19'h00555, 8'hF0, S0);
        wr(19'h00555, 8'hAA, S0); idle(TMO);
        wr(19'h00AAA, 8'h55, S0); wr(19'h00555, 8'h90, S0);
        rd(19'h00001, S0, arr(19'h00001), "R4");

        // R9 / R12: program, busy status, ignored write, done
        unlock(); wr(19'h00555, 8'hA0, S0);
        expect_stb(3'd0, 19'h01234, 8'h3C, "R9");
        wr(19'h01234, 8'h3C, S0);
        rd(19'h00000, S0, 8'h00, "R12");
        wr(19'h00000, 8'hB0, S0);
        rd(19'h00000, S0, 8'h00, "R12");
        done_pulse();
        rd(19'h00044, S0, arr(19'h00044), "R12");

        // R11: program and sector erase on protected sector are dropped
        unlock(); wr(19'h00555, 8'hA0, S0);
        wr(19'h0ABCD, 8'h77, S2);
        rd(19'h00033, S0, arr(19'h00033), "R11");
        unlock(); wr(19'h00555, 8'h80, S0); unlock();
        wr(19'h40000, 8'h30, S2);
        rd(19'h00034, S0, arr(19'h00034), "R11");

        // R10 / R12: sector erase with suspend and resume
        unlock(); wr(19'h00555, 8'h80, S0); unlock();
        expect_stb(3'd2, 19'h20000, 8'h30, "R10");
        wr(19'h20000, 8'h30, S1);
        rd(19'h00000, S1, 8'h08, "R12");
        expect_stb(3'd3, 19'h00000, 8'hB0, "R12");
        wr(19'h00000, 8'hB0, S1);
        rd(19'h00000, S1, 8'h09, "R12");
        expect_stb(3'd4, 19'h00000, 8'h30, "R12");
        wr(19'h00000, 8'h30, S1);
        rd(19'h00000, S1, 8'h08, "R12");
        done_pulse();
        rd(19'h00055, S0, arr(19'h00055), "R12");

        // R11 / R10: chip erase blocked by protection, then allowed
        unlock(); wr(19'h00555, 8'h80, S0); unlock();
        wr(19'h00555, 8'h10, S0);
        rd(19'h00066, S0, arr(19'h00066), "R11");
        load_prot('0);
        unlock(); wr(19'h00555, 8'h80, S0); unlock();
        expect_stb(3'd1, 19'h00555, 8'h10, "R10");
        wr(19'h00555, 8'h10, S0);
        rd(19'h00000, S0, 8'h08, "R10");
        wr(19'h00000, 8'hB0, S0);                 // no suspend for chip erase
        rd(19'h00000, S0, 8'h08, "R12");
        done_pulse();
        rd(19'h00077, S0, arr(19'h00077), "R10");

        idle(4);
        finish_run();
    end
endmodule